// File: doc/BRIEF.md
# Successive-Approximation Converter Controller with Split-Enable Result Bus

This block is the digital sequencer of a successive-approximation converter. A start request makes it spend one clock in a sample phase. It then resolves the result one bit per clock, starting at the most significant bit. In each decision clock it presents a trial code to an external DAC and comparator, and reads back one comparator bit that says whether the input is at or above that trial level.

When the last bit is decided, the block copies the finished word into an edge-triggered output register and raises a sticky data-ready flag. The host reads the word over a bus with two independently enabled groups: the upper bits and the two lowest bits. A disabled group drives zero with its enable flag low, which models a high-impedance driver. The host clears the flag with a ready-reset input, or implicitly by issuing the next start. The output register keeps the previous result for the whole of the following conversion.

Top module: `sar_bus_ctrl`

## Requirements
- R1: While the asynchronous active-low reset is applied, and on release, the output register is zero and both `dataReady` and `busy` are low.
- R2: The latched result is the largest code whose trial level the comparator reports as at or below the input. A comparator result of 1 (input at or above the trial) keeps the trial bit, and 0 clears it. With an ideal comparator the result therefore equals the input code, including both end codes 0 and 1023.
- R3: A start sampled on clock edge E0 gives `dataReady` high and `busy` low after edge E12. `busy` is high after E0 through E11, and `dataReady` stays low through E11.
- R4: The output register does not change between a start and the completion of the conversion that start launches.
- R5: `oeHigh` puts output bits 9..2 on `busHi` with `busHiEn` high. `oeLow` puts bits 1..0 on `busLo` with `busLoEn` high. A group whose enable is low drives zeros with its flag low, and neither enable affects the other group.
- R6: `readyClr` high on an edge outside the final transfer clock makes `dataReady` low after that edge, and leaves the output register unchanged.
- R7: A start sampled on an edge makes `dataReady` low after that edge.
- R8: A start sampled during a conversion abandons it and restarts the full 12-clock sequence from that edge. The abandoned search never reaches the output register.
- R9: In the clock after E1, `trialCode` is 0x200. After the MSB decision on E2 it is 0x100, with bit 9 equal to the kept MSB.
- R10: If the clock stops during the sample clock, the outputs stay unchanged. When the clock resumes, the conversion completes with the correct result in the remaining clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Synchronous start, active high |
| readyClr | input | 1 | Synchronous ready-flag clear, active high |
| cmpHigh | input | 1 | Comparator: 1 when the input is at or above the trial level |
| oeHigh | input | 1 | Enable for the upper result group |
| oeLow | input | 1 | Enable for the lower result group |
| trialCode | output | 10 | Trial code to the DAC |
| busHi | output | 8 | Result bits 9..2, zero when disabled |
| busHiEn | output | 1 | Upper group is driven |
| busLo | output | 2 | Result bits 1..0, zero when disabled |
| busLoEn | output | 1 | Lower group is driven |
| dataReady | output | 1 | Sticky result-ready flag |
| busy | output | 1 | Conversion in progress |

## Verification
Timing is counted in edges from the edge that samples the start.
- The first trial code appears after edge E1, and the MSB decision is visible after E2.
- The new result and the ready flag are due after E12, and the bench confirms that the flag is still low after E11.
- The effects of a flag clear or a start are due after the single edge that samples them.
- The bus groups are combinational, so they are read a short settle time after the enables change.

All inputs change on falling edges, and outputs are sampled on falling edges, so each check falls exactly on the clock boundary where its result is due.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_DECIDE,
    ST_XFER
  } sarState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic restart;   // start seen: clear search word and ready flag
    logic seed;      // leaving the sample clock: set MSB trial
    logic decide;    // resolve the bit at bitIdx, try the next lower one
    logic transfer;  // copy search word to the output register
  } sarStrobe_t;

endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int WIDTH = 10,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  output sarStrobe_t       strobe,
  output logic [IDX_W-1:0] bitIdx,
  output logic             busy
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);

  sarState_e state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
    end else if (startReq) begin
      state  <= ST_SAMPLE;
      bitIdx <= TOP_IDX;
    end else begin
      case (state)
        ST_SAMPLE: begin
          state  <= ST_DECIDE;
          bitIdx <= TOP_IDX;
        end
        ST_DECIDE: begin
          if (bitIdx == '0) state <= ST_XFER;
          else              bitIdx <= bitIdx - 1'b1;
        end
        ST_XFER:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.restart  = startReq;
    strobe.seed     = (state == ST_SAMPLE) && !startReq;
    strobe.decide   = (state == ST_DECIDE) && !startReq;
    strobe.transfer = (state == ST_XFER)   && !startReq;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int WIDTH   = 10,
  parameter int LO_BITS = 2,
  localparam int IDX_W  = $clog2(WIDTH),
  localparam int HI_BITS = WIDTH - LO_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  sarStrobe_t         strobe,
  input  logic [IDX_W-1:0]   bitIdx,
  input  logic               cmpHigh,
  input  logic               readyClr,
  input  logic               oeHigh,
  input  logic               oeLow,
  output logic [WIDTH-1:0]   trialCode,
  output logic [HI_BITS-1:0] busHi,
  output logic               busHiEn,
  output logic [LO_BITS-1:0] busLo,
  output logic               busLoEn,
  output logic               dataReady
);

  logic [WIDTH-1:0] sarReg, sarNext, outReg;

  always_comb begin
    sarNext = sarReg;
    if (strobe.restart) begin
      sarNext = '0;
    end else if (strobe.seed) begin
      sarNext = '0;
      sarNext[WIDTH-1] = 1'b1;
    end else if (strobe.decide) begin
      for (int b = 0; b < WIDTH; b++) begin
        if (int'(bitIdx) == b)          sarNext[b] = cmpHigh;
        else if (int'(bitIdx) == b + 1) sarNext[b] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarReg    <= '0;
      outReg    <= '0;
      dataReady <= 1'b0;
    end else begin
      sarReg <= sarNext;
      if (strobe.transfer) outReg <= sarReg;
      if (strobe.restart)       dataReady <= 1'b0;
      else if (strobe.transfer) dataReady <= 1'b1;
      else if (readyClr)        dataReady <= 1'b0;
    end
  end

  assign trialCode = sarReg;

  generate
    if (HI_BITS > 0) begin : g_hi
      assign busHi   = oeHigh ? outReg[WIDTH-1:LO_BITS] : '0;
      assign busHiEn = oeHigh;
    end
    if (LO_BITS > 0) begin : g_lo
      assign busLo   = oeLow ? outReg[LO_BITS-1:0] : '0;
      assign busLoEn = oeLow;
    end
  endgenerate

endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH   = 10,
  parameter int LO_BITS = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startReq,
  input  logic                       readyClr,
  input  logic                       cmpHigh,
  input  logic                       oeHigh,
  input  logic                       oeLow,
  output logic [WIDTH-1:0]           trialCode,
  output logic [WIDTH-LO_BITS-1:0]   busHi,
  output logic                       busHiEn,
  output logic [LO_BITS-1:0]         busLo,
  output logic                       busLoEn,
  output logic                       dataReady,
  output logic                       busy
);

  localparam int IDX_W = $clog2(WIDTH);

  sarStrobe_t       strobe;
  logic [IDX_W-1:0] bitIdx;

  sar_seq #(.WIDTH(WIDTH)) u_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .strobe(strobe), .bitIdx(bitIdx), .busy(busy)
  );

  sar_datapath #(.WIDTH(WIDTH), .LO_BITS(LO_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitIdx(bitIdx),
    .cmpHigh(cmpHigh), .readyClr(readyClr), .oeHigh(oeHigh), .oeLow(oeLow),
    .trialCode(trialCode), .busHi(busHi), .busHiEn(busHiEn),
    .busLo(busLo), .busLoEn(busLoEn), .dataReady(dataReady)
  );

endmodule

// File: rtl/sar_bus_ctrl_chk.sv
module sar_bus_ctrl_chk #(
  parameter int WIDTH   = 10,
  parameter int LO_BITS = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     startReq,
  input logic                     readyClr,
  input logic                     oeHigh,
  input logic [WIDTH-1:0]         trialCode,
  input logic [WIDTH-LO_BITS-1:0] busHi,
  input logic                     dataReady,
  input logic                     busy
);

  localparam logic [WIDTH-1:0] MSB_TRIAL = {1'b1, {(WIDTH-1){1'b0}}};

  // R3: ready can only rise out of a conversion
  assert_ready_after_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReady) |-> $past(busy));

  // R3: a conversion never ends without its result flagged
  assert_done_flags_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> dataReady);

  // R4: upper result group frozen while a conversion runs
  assert_hold_during_conv_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && oeHigh && $past(oeHigh)) |-> $stable(busHi));

  // R6: clear outside a conversion drops the flag
  assert_clear_drops_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    (readyClr && !busy && !startReq) |=> !dataReady);

  // R7: start drops the flag
  assert_start_drops_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> !dataReady);

  // R9: the first trial after the sample clock is the MSB alone
  assert_first_trial_msb_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !startReq) |=> (trialCode == MSB_TRIAL));

endmodule

bind sar_bus_ctrl sar_bus_ctrl_chk #(.WIDTH(WIDTH), .LO_BITS(LO_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .readyClr(readyClr),
  .oeHigh(oeHigh), .trialCode(trialCode), .busHi(busHi),
  .dataReady(dataReady), .busy(busy)
);

// File: tb/sar_bus_ctrl_bench.sv
module sar_bus_ctrl_bench;

  logic clk = 1'b0;
  logic clkRun = 1'b1;
  logic rstN = 1'b0;
  logic startReq = 1'b0, readyClr = 1'b0, oeHigh = 1'b0, oeLow = 1'b0;
  logic [9:0] vin = '0;
  logic [9:0] trialCode;
  logic [7:0] busHi;
  logic [1:0] busLo;
  logic busHiEn, busLoEn, dataReady, busy;
  logic cmpHigh;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always begin
    #2;
    if (clkRun) clk = ~clk;
  end

  // ideal comparator model
  assign cmpHigh = (vin >= trialCode);

  sar_bus_ctrl u_sar_bus_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .readyClr(readyClr),
    .cmpHigh(cmpHigh), .oeHigh(oeHigh), .oeLow(oeLow), .trialCode(trialCode),
    .busHi(busHi), .busHiEn(busHiEn), .busLo(busLo), .busLoEn(busLoEn),
    .dataReady(dataReady), .busy(busy)
  );

  // {input code, expected result}
  localparam logic [19:0] VEC [8] = '{
    {10'd512,  10'd512},  {10'd0,    10'd0},   {10'd1023, 10'd1023},
    {10'd511,  10'd511},  {10'd341,  10'd341}, {10'd682,  10'd682},
    {10'd1,    10'd1},    {10'd1022, 10'd1022}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readWord(output int word);
    oeHigh = 1'b1;
    oeLow = 1'b1;
    #1;
    word = {busHi, busLo};
  endtask

  task automatic pulseStart();
    startReq = 1'b1;
    tick();
    startReq = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int word;
    int prev;
    @(negedge clk);
    @(negedge clk);

    // R1: reset state
    check("R1 ready in reset", int'(dataReady), 0);
    check("R1 busy in reset", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    readWord(word);
    check("R1 result after reset", word, 0);
    check("R1 ready after reset", int'(dataReady), 0);

    prev = 0;
    for (int v = 0; v < 8; v++) begin
      vin = VEC[v][19:10];
      pulseStart();                                   // after E0
      check("R7 ready after start", int'(dataReady), 0);
      check("R3 busy after start", int'(busy), 1);
      for (int e = 1; e <= 11; e++) begin
        tick();
        if (e == 1) check("R9 first trial", int'(trialCode), 'h200);
        if (e == 2) check("R9 second trial", int'(trialCode),
                          int'((vin & 10'h200) | 10'h100));
        if (e == 6) begin
          readWord(word);
          check("R4 held result", word, prev);
        end
        if (e == 11) begin
          check("R3 ready low at E11", int'(dataReady), 0);
          check("R3 busy at E11", int'(busy), 1);
        end
      end
      tick();                                         // E12
      check("R3 ready at E12", int'(dataReady), 1);
      check("R3 busy low at E12", int'(busy), 0);
      readWord(word);
      check("R2 result", word, int'(VEC[v][9:0]));
      prev = word;
    end

    // R5: split enables, last result 1022 = 0b11111111_10
    oeHigh = 1'b1; oeLow = 1'b0; #1;
    check("R5 hi group", int'(busHi), 8'hFF);
    check("R5 lo disabled value", int'(busLo), 0);
    check("R5 lo flag", int'(busLoEn), 0);
    oeHigh = 1'b0; oeLow = 1'b1; #1;
    check("R5 lo group", int'(busLo), 2);
    check("R5 hi disabled value", int'(busHi), 0);
    check("R5 hi flag", int'(busHiEn), 0);

    // R6: clear flag, data untouched
    readyClr = 1'b1;
    tick();
    readyClr = 1'b0;
    check("R6 ready cleared", int'(dataReady), 0);
    readWord(word);
    check("R6 data kept", word, 1022);

    // R8: restart mid-conversion
    vin = 10'd100;
    pulseStart();
    for (int e = 1; e <= 5; e++) tick();
    vin = 10'd900;
    pulseStart();                                     // new E0
    for (int e = 1; e <= 11; e++) tick();
    check("R8 ready low before new E12", int'(dataReady), 0);
    readWord(word);
    check("R8 old result still held", word, 1022);
    tick();
    check("R8 ready at new E12", int'(dataReady), 1);
    readWord(word);
    check("R8 restarted result", word, 900);

    // R10: clock stopped during sample clock
    vin = 10'd333;
    pulseStart();                                     // now in sample clock, clk low
    clkRun = 1'b0;
    #200;
    readWord(word);
    check("R10 output while stopped", word, 900);
    check("R10 busy while stopped", int'(busy), 1);
    check("R10 trial while stopped", int'(trialCode), 0);
    clkRun = 1'b1;
    for (int e = 1; e <= 11; e++) tick();
    check("R10 ready low at E11", int'(dataReady), 0);
    tick();
    check("R10 ready after resume", int'(dataReady), 1);
    readWord(word);
    check("R10 result after resume", word, 333);

    // R1: asynchronous reset clears everything
    #1 rstN = 1'b0;
    #1;
    readWord(word);
    check("R1 result on reset", word, 0);
    check("R1 ready on reset", int'(dataReady), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule